// File: doc/BRIEF.md
# UART Bank-0 Register Front-End

This block sits between a CPU bus and the data path of a UART that has transmit and receive FIFOs. It takes a three-bit offset with read and write strobes. It decodes the bank-0 register set: the shared data port, the interrupt enable register, the FIFO control register, the line control / bank select register and a scratch register. Data-port traffic is steered either into single-entry holding registers or into 16-entry FIFOs, depending on the FIFO mode. Separate DMA request and acknowledge strobes move bytes in and out of the same transmit and receive paths, whatever bank is selected.

The serial shifter sees the transmit path as a head byte with a valid flag and a pop strobe. It feeds the receive path through a push strobe. Event lines from the rest of the UART are gated by the interrupt enables to form a registered interrupt output. The four upper enable bits exist only while the extended-mode input is high.

Top module: `uart_regfront`

## Requirements
- R1: After reset, rdata, irq, tx_valid, tx_ovr and dma_rx_req are 0 and dma_tx_req is 1. The interrupt enables, line control, scratch register and FIFO mode are all 0.
- R2: A CPU write to offset 0 pushes wdata into the transmit path, so tx_valid and tx_data show it after that clock edge. A CPU read of offset 0 pops the receive path, and the byte appears on rdata after that edge.
- R3: With FIFO mode off, each path holds one entry. A transmit write while that entry is occupied is dropped and sets the sticky tx_ovr flag. tx_pop drains the entry.
- R4: With FIFO mode on, the transmit path accepts 16 bytes and returns them in write order. A 17th write is dropped and sets tx_ovr, and dma_tx_req is 0 while the path is full.
- R5: A data-port read while the receive path is empty returns the last byte popped and removes nothing.
- R6: Offset 1 holds the interrupt enables: bit 0 rx high level, bit 1 tx low level, bit 2 line status, bit 3 reserved, bits 4..7 DMA, tx empty, status FIFO, timer. Bit 3 always reads 0.
- R7: Enable bits 7..4 can be written to 1 only while ext_mode is 1. They are cleared on every clock edge at which ext_mode is 0.
- R8: irq equals the OR over all bits of evt AND the enables, registered one cycle.
- R9: Bit 0 of a write to offset 2 sets FIFO mode, and a read of offset 2 returns it in bit 0. A write that changes the mode empties both paths and clears tx_ovr. A write of the same mode changes nothing.
- R10: Offset 3 is an 8-bit read/write line control register, always reachable. While its bit 7 is 1, CPU accesses to every other offset are ignored and read as 0.
- R11: dma_tx_ack pushes dma_wdata into the transmit path and dma_rx_ack pops the receive path onto rdata, whatever the value of bit 7 of the line control register. dma_tx_req is 1 while the transmit path is not full, and dma_rx_req is 1 while the receive path is not empty.
- R12: Offset 7 is an 8-bit read/write scratch register. Offsets 4, 5 and 6 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | CPU register offset |
| wr_en | input | 1 | CPU write strobe |
| rd_en | input | 1 | CPU read strobe |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | Registered read data (CPU or DMA) |
| ext_mode | input | 1 | Extended mode active |
| evt | input | 8 | Pending interrupt events, one per enable bit |
| irq | output | 1 | Registered interrupt request |
| dma_tx_req | output | 1 | Transmit path has room |
| dma_tx_ack | input | 1 | DMA write strobe |
| dma_wdata | input | 8 | DMA write data |
| dma_rx_req | output | 1 | Receive path holds data |
| dma_rx_ack | input | 1 | DMA read strobe |
| tx_data | output | 8 | Head of the transmit path |
| tx_valid | output | 1 | Transmit path not empty |
| tx_pop | input | 1 | Shifter takes the head byte |
| rx_din | input | 8 | Byte from the shifter |
| rx_push | input | 1 | Shifter delivers rx_din |
| tx_ovr | output | 1 | Sticky transmit overrun flag |

## Verification
Every result is due one clock edge after its stimulus. This covers rdata after a read strobe, tx_valid, tx_data, the request lines and tx_ovr after a push or pop, the enables after an ext_mode change, and irq after evt. The bench drives every strobe at a falling edge and samples at the following falling edge, so exactly one rising edge lies between them. Vector reads insert one idle cycle after changing ext_mode, so that the enable clearing has finished before the register is read back.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IEN  = 3'd1;
  localparam logic [2:0] OFS_FCTL = 3'd2;
  localparam logic [2:0] OFS_LCTL = 3'd3;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  typedef struct packed {
    logic data;
    logic ien;
    logic fctl;
    logic lctl;
    logic scr;
  } rf_sel_t;
endpackage

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          cap_one,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = cap_one ? (count != '0) : (count == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rd_ptr];

  // storage has no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
(
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       bank_alt,
  output rf_sel_t    wsel,
  output rf_sel_t    rsel
);
  rf_sel_t hit;

  always_comb begin
    hit      = '0;
    hit.lctl = (addr == OFS_LCTL);
    if (!bank_alt) begin
      hit.data = (addr == OFS_DATA);
      hit.ien  = (addr == OFS_IEN);
      hit.fctl = (addr == OFS_FCTL);
      hit.scr  = (addr == OFS_SCR);
    end
  end

  assign wsel = wr_en ? hit : '0;
  assign rsel = rd_en ? hit : '0;
endmodule

// File: rtl/uart_rf_ien.sv
module uart_rf_ien #(
  parameter int NEV = 8,
  parameter int EXT_LO = 4,
  parameter int RSV_BIT = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ext_mode,
  input  logic           we,
  input  logic [NEV-1:0] wdata,
  input  logic [NEV-1:0] evt,
  output logic [NEV-1:0] ien,
  output logic           irq
);
  logic [NEV-1:0] keep_mask;

  // bits that survive a non-extended cycle; reserved bit never writable
  always_comb begin
    for (int i = 0; i < NEV; i++) begin
      keep_mask[i] = (i != RSV_BIT) && ((i < EXT_LO) || ext_mode);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien <= '0;
      irq <= 1'b0;
    end else begin
      if (we) ien <= wdata & keep_mask;
      else    ien <= ien & keep_mask;
      irq <= |(evt & ien);
    end
  end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          ext_mode,
  input  logic [DW-1:0] evt,
  output logic          irq,
  output logic          dma_tx_req,
  input  logic          dma_tx_ack,
  input  logic [DW-1:0] dma_wdata,
  output logic          dma_rx_req,
  input  logic          dma_rx_ack,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_pop,
  input  logic [DW-1:0] rx_din,
  input  logic          rx_push,
  output logic          tx_ovr
);
  rf_sel_t       wsel, rsel;
  logic [DW-1:0] ier_q, lctl_q, scr_q, last_rx, rx_dout, rx_val;
  logic          fifo_en, flush;
  logic          tx_push, tx_empty, tx_full, rx_pop, rx_empty, rx_full;
  logic [CW-1:0] tx_count, rx_count;

  uart_rf_decode u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .bank_alt(lctl_q[DW-1]),
    .wsel(wsel), .rsel(rsel)
  );

  uart_rf_ien #(.NEV(DW)) u_ien (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .we(wsel.ien),
    .wdata(wdata), .evt(evt), .ien(ier_q), .irq(irq)
  );

  assign flush   = wsel.fctl & (wdata[0] != fifo_en);
  assign tx_push = wsel.data | dma_tx_ack;
  assign rx_pop  = rsel.data | dma_rx_ack;

  uart_rf_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(flush), .cap_one(~fifo_en),
    .push(tx_push), .din(dma_tx_ack ? dma_wdata : wdata), .pop(tx_pop),
    .dout(tx_data), .empty(tx_empty), .full(tx_full), .count(tx_count)
  );

  uart_rf_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(flush), .cap_one(~fifo_en),
    .push(rx_push), .din(rx_din), .pop(rx_pop),
    .dout(rx_dout), .empty(rx_empty), .full(rx_full), .count(rx_count)
  );

  assign tx_valid   = ~tx_empty;
  assign dma_tx_req = ~tx_full;
  assign dma_rx_req = ~rx_empty;
  assign rx_val     = rx_empty ? last_rx : rx_dout;

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en <= 1'b0;
      lctl_q  <= '0;
      scr_q   <= '0;
      tx_ovr  <= 1'b0;
      last_rx <= '0;
      rdata   <= '0;
    end else begin
      if (wsel.fctl) fifo_en <= wdata[0];
      if (wsel.lctl) lctl_q  <= wdata;
      if (wsel.scr)  scr_q   <= wdata;
      if (flush)                     tx_ovr <= 1'b0;
      else if (tx_push && tx_full)   tx_ovr <= 1'b1;
      if (rx_pop && !rx_empty) last_rx <= rx_dout;
      if (rd_en) begin
        unique case (1'b1)
          rsel.data: rdata <= rx_val;
          rsel.ien:  rdata <= ier_q;
          rsel.fctl: rdata <= {{(DW-1){1'b0}}, fifo_en};
          rsel.lctl: rdata <= lctl_q;
          rsel.scr:  rdata <= scr_q;
          default:   rdata <= '0;
        endcase
      end else if (dma_rx_ack) begin
        rdata <= rx_val;
      end
    end
  end

  // receive overrun has no flag in this block: rx_full only gates pushes
  logic unused_ok;
  assign unused_ok = rx_full;
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          ext_mode,
  input logic [7:0]    ier_q,
  input logic [7:0]    evt,
  input logic          irq,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic          tx_ovr,
  input logic          flush,
  input logic          unused_ok
);
  a_r7_upper_clear: assert property (@(posedge clk) disable iff (rst)
    !ext_mode |=> (ier_q[7:4] == 4'h0));

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    ier_q[3] == 1'b0);

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(evt) & $past(ier_q))));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (int'(tx_count) <= DEPTH) && (int'(rx_count) <= DEPTH));

  a_r3_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    (tx_ovr && !flush) |=> tx_ovr);

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (tx_count == '0 && rx_count == '0 && !tx_ovr));

  logic chk_unused;
  assign chk_unused = unused_ok;
endmodule

bind uart_regfront uart_regfront_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .ext_mode(ext_mode), .ier_q(ier_q), .evt(evt),
  .irq(irq), .tx_count(tx_count), .rx_count(rx_count), .tx_ovr(tx_ovr),
  .flush(flush), .unused_ok(unused_ok)
);

// File: tb/sim_uart_regfront.sv
`timescale 1ns/1ps
module sim_uart_regfront;
  logic       clk = 1'b0, rst = 1'b1;
  logic [2:0] addr = '0;
  logic       wr_en = 0, rd_en = 0, ext_mode = 0;
  logic [7:0] wdata = '0, rdata, evt = '0, dma_wdata = '0, tx_data, rx_din = '0;
  logic       irq, dma_tx_req, dma_tx_ack = 0, dma_rx_req, dma_rx_ack = 0;
  logic       tx_valid, tx_pop = 0, rx_push = 0, tx_ovr;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  uart_regfront u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .ext_mode(ext_mode), .evt(evt), .irq(irq),
    .dma_tx_req(dma_tx_req), .dma_tx_ack(dma_tx_ack), .dma_wdata(dma_wdata),
    .dma_rx_req(dma_rx_req), .dma_rx_ack(dma_rx_ack), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_pop(tx_pop), .rx_din(rx_din), .rx_push(rx_push),
    .tx_ovr(tx_ovr)
  );

  // vector: {ext_mode, is_write, offset[2:0], wdata[7:0], expected[7:0]}
  localparam int NV = 20;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 1'b1, 3'd1, 8'hFF, 8'h00},  // R7 write all enables in ext mode
    {1'b1, 1'b0, 3'd1, 8'h00, 8'hF7},  // R6 bit 3 reads 0
    {1'b0, 1'b0, 3'd1, 8'h00, 8'h07},  // R7 upper bits cleared
    {1'b0, 1'b1, 3'd1, 8'hFF, 8'h00},
    {1'b0, 1'b0, 3'd1, 8'h00, 8'h07},  // R7 cannot set upper bits
    {1'b0, 1'b1, 3'd7, 8'hA5, 8'h00},
    {1'b0, 1'b0, 3'd7, 8'h00, 8'hA5},  // R12 scratch
    {1'b0, 1'b1, 3'd3, 8'h03, 8'h00},
    {1'b0, 1'b0, 3'd3, 8'h00, 8'h03},  // R10 line control
    {1'b0, 1'b0, 3'd4, 8'h00, 8'h00},  // R12 unmapped
    {1'b0, 1'b0, 3'd5, 8'h00, 8'h00},
    {1'b0, 1'b0, 3'd6, 8'h00, 8'h00},
    {1'b0, 1'b0, 3'd2, 8'h00, 8'h00},  // R9 fifo mode off
    {1'b0, 1'b1, 3'd3, 8'h80, 8'h00},  // R10 alternate bank
    {1'b0, 1'b1, 3'd7, 8'h11, 8'h00},
    {1'b0, 1'b0, 3'd7, 8'h00, 8'h00},
    {1'b0, 1'b0, 3'd3, 8'h00, 8'h80},
    {1'b0, 1'b1, 3'd3, 8'h00, 8'h00},
    {1'b0, 1'b0, 3'd7, 8'h00, 8'hA5},  // R10 ignored write left scratch
    {1'b0, 1'b1, 3'd1, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic cpu_rd(input logic [2:0] a);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic shift_in(input logic [7:0] d);
    @(negedge clk); rx_din = d; rx_push = 1;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic shift_out();
    @(negedge clk); tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
    chk("R1 tx_ovr", {7'b0, tx_ovr}, 8'h00);
    chk("R1 dma_tx_req", {7'b0, dma_tx_req}, 8'h01);
    chk("R1 dma_rx_req", {7'b0, dma_rx_req}, 8'h00);
    cpu_rd(3'd1);
    chk("R1 ier", rdata, 8'h00);

    // register vectors: R6 R7 R9 R10 R12
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); ext_mode = VEC[i][20];
      if (VEC[i][19]) cpu_wr(VEC[i][18:16], VEC[i][15:8]);
      else begin
        cpu_rd(VEC[i][18:16]);
        chk($sformatf("R6/R7/R10/R12 vector %0d", i), rdata, VEC[i][7:0]);
      end
    end

    // R3 holding mode, single entry
    cpu_wr(3'd0, 8'hA1);
    chk("R2 tx_valid", {7'b0, tx_valid}, 8'h01);
    chk("R2 tx_data", tx_data, 8'hA1);
    chk("R3 full req", {7'b0, dma_tx_req}, 8'h00);
    cpu_wr(3'd0, 8'hB2);
    chk("R3 ovr set", {7'b0, tx_ovr}, 8'h01);
    chk("R3 head kept", tx_data, 8'hA1);
    shift_out();
    chk("R3 drained", {7'b0, tx_valid}, 8'h00);
    chk("R3 ovr sticky", {7'b0, tx_ovr}, 8'h01);

    // R9 toggle flushes, same value does not
    shift_in(8'h55);
    chk("R9 rx before", {7'b0, dma_rx_req}, 8'h01);
    cpu_wr(3'd2, 8'h01);
    chk("R9 ovr clear", {7'b0, tx_ovr}, 8'h00);
    chk("R9 rx flushed", {7'b0, dma_rx_req}, 8'h00);
    cpu_rd(3'd2);
    chk("R9 mode read", rdata, 8'h01);
    cpu_wr(3'd0, 8'h77);
    cpu_wr(3'd2, 8'h01);
    chk("R9 same mode no flush", {7'b0, tx_valid}, 8'h01);
    shift_out();

    // R4 sixteen deep, in order, 17th dropped
    for (int i = 0; i < 16; i++) cpu_wr(3'd0, 8'h10 + 8'(i));
    chk("R4 full req", {7'b0, dma_tx_req}, 8'h00);
    chk("R4 no ovr yet", {7'b0, tx_ovr}, 8'h00);
    cpu_wr(3'd0, 8'hEE);
    chk("R4 ovr", {7'b0, tx_ovr}, 8'h01);
    for (int i = 0; i < 16; i++) begin
      chk($sformatf("R4 order %0d", i), tx_data, 8'h10 + 8'(i));
      shift_out();
    end
    chk("R4 empty", {7'b0, tx_valid}, 8'h00);

    // R2 / R5 receive reads
    shift_in(8'hC1); shift_in(8'hC2); shift_in(8'hC3);
    cpu_rd(3'd0); chk("R2 rx 1", rdata, 8'hC1);
    cpu_rd(3'd0); chk("R2 rx 2", rdata, 8'hC2);
    cpu_rd(3'd0); chk("R2 rx 3", rdata, 8'hC3);
    cpu_rd(3'd0); chk("R5 empty read", rdata, 8'hC3);
    shift_in(8'hD4);
    cpu_rd(3'd0); chk("R5 no pop", rdata, 8'hD4);

    // R11 DMA ignores bank
    cpu_wr(3'd3, 8'h80);
    @(negedge clk); dma_wdata = 8'h5A; dma_tx_ack = 1;
    @(negedge clk); dma_tx_ack = 0;
    chk("R11 dma tx", tx_data, 8'h5A);
    shift_out();
    shift_in(8'h6B);
    chk("R11 rx req", {7'b0, dma_rx_req}, 8'h01);
    @(negedge clk); dma_rx_ack = 1;
    @(negedge clk); dma_rx_ack = 0;
    chk("R11 dma rx", rdata, 8'h6B);
    shift_in(8'h7C);
    cpu_rd(3'd0); chk("R10 data read blocked", rdata, 8'h00);
    chk("R10 no pop", {7'b0, dma_rx_req}, 8'h01);
    cpu_wr(3'd3, 8'h00);
    cpu_rd(3'd0); chk("R10 bank back", rdata, 8'h7C);

    // R8 interrupt gating
    @(negedge clk); ext_mode = 1;
    cpu_wr(3'd1, 8'h11);
    @(negedge clk); evt = 8'h01;
    @(negedge clk); chk("R8 low bit", {7'b0, irq}, 8'h01);
    evt = 8'h10;
    @(negedge clk); chk("R8 ext bit", {7'b0, irq}, 8'h01);
    evt = 8'h02;
    @(negedge clk); chk("R8 masked", {7'b0, irq}, 8'h00);
    ext_mode = 0; evt = 8'h00;
    @(negedge clk); evt = 8'h10;
    @(negedge clk); chk("R7 ext bit gone", {7'b0, irq}, 8'h00);
    evt = 8'h00;

    finish_run();
  end
endmodule